// File: doc/BRIEF.md
# Physical Register Reclamation by Use Counting

This block decides, register by register, when a physical register of an out-of-order core may go back to the free pool. There is no reorder buffer. Each physical register carries a small use counter, a flag that says a newer mapping has replaced it, and a bit in a free vector. Sources named at rename raise the counter, and sources read at issue lower it. Taking a checkpoint raises the counter of every register live in the map at that moment, and dropping that checkpoint lowers the same set. A register that is no longer mapped and has no pending use is released one clock later. The same clock edge sets its free bit and pulses its bit in a freed mask.

Rename events and checkpoint captures are the only inputs that can add to a counter. They share one valid/ready pair. `ren_ready` is low when an offered increment would push some counter past its maximum. A held-off event has no effect at all, and its source must keep offering it, unchanged, until it sees `ren_ready` high. Issue reads and checkpoint drops only subtract, so they are always taken and have no handshake. `ren_ready` is worked out combinationally from the current counters and the offered increments. Decrements offered in the same cycle do not lower it.

Top module: `rc_preg_reclaim`

## Requirements
- R1: After reset, registers 0 to 15 are held (free bit 0, counter 0, flag clear), registers 16 to 63 are free (free bit 1), `freed_mask` is zero and `ren_ready` is 1.
- R2: Each valid source tag of an accepted rename event adds one to that register's counter. A register that is replaced while it still has pending uses stays held.
- R3: `ren_ready` is 0 exactly when, for some register, its counter plus the increments offered this cycle (rename sources when `ren_valid`, plus one when `ckpt_take` and its mask bit is set) exceeds 15. An event offered while `ren_ready` is 0 changes no counter, no flag and no free bit. With no increment offered, `ren_ready` is 1.
- R4: Each valid issue source tag subtracts one from that register's counter, in every cycle, whatever the state of `ren_ready`.
- R5: An accepted `ckpt_take` adds one to every register whose bit is set in `ckpt_take_mask`. `ckpt_drop` subtracts one from every register whose bit is set in `ckpt_drop_mask`.
- R6: All increments and decrements that reach one register in one cycle are summed into a single net update. An add and a subtract in the same cycle leave the counter unchanged.
- R7: A held register whose flag is set and whose updated counter is zero becomes free at the next clock edge. At that edge its free bit rises, its flag clears, and its `freed_mask` bit is 1 for exactly that one cycle. Every rising free bit is matched by its freed bit.
- R8: An accepted rename with `ren_dst_vld` set does two things. It sets the flag of `ren_old_tag`. It clears the free bit, the counter and the flag of `ren_new_tag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ren_valid | input | 1 | A rename event is offered |
| ren_ready | output | 1 | The rename event and any checkpoint capture are accepted this cycle |
| ren_src_vld | input | 2 | Per-slot valid bits for rename source tags |
| ren_src_tag | input | 12 | Rename source tags, slot k at bits [6k+5:6k] |
| ren_dst_vld | input | 1 | The event remaps a logical destination |
| ren_old_tag | input | 6 | Register being replaced |
| ren_new_tag | input | 6 | Register being allocated |
| iss_src_vld | input | 2 | Per-slot valid bits for issue reads |
| iss_src_tag | input | 12 | Issue source tags, slot k at bits [6k+5:6k] |
| ckpt_take | input | 1 | Capture a checkpoint (gated by `ren_ready`) |
| ckpt_take_mask | input | 64 | Registers live in the map at capture |
| ckpt_drop | input | 1 | Drop a checkpoint |
| ckpt_drop_mask | input | 64 | Registers that were live when that checkpoint was captured |
| free_vec | output | 64 | Free vector, bit i = register i free |
| freed_mask | output | 64 | Registers released at the last clock edge |

## Verification
The bench goes after four cases.

- **Replacing a register that still has uses.** An instruction can read a register and then replace it in the same event. A design that frees on the flag alone would hand out that register while a reader is still waiting for it.
- **Counter saturation.** Sixteen checkpoint captures are aimed at one register. A design without the stall would wrap the counter to zero and release a live register. A design that stalls but still applies the rejected event would hand out the offered destination anyway.
- **Add and subtract in one cycle.** The bench drives a rename read and an issue read of the same register in one cycle. A design that drops one of the two would either free the register early or never free it.
- **The timing of the freed pulse.** The bench checks that the pulse comes exactly on the edge where the free bit rises and lasts one cycle.

// File: rtl/rc_pkg.sv
`timescale 1ns/1ps
package rc_pkg;

  // Per-register status bits kept next to the use counter
  typedef struct packed {
    logic free;     // register sits in the free pool
    logic renamed;  // a newer mapping has replaced this register
  } rc_flags_t;

  // Width of a per-cycle delta: up to n_max tag hits plus one checkpoint bit
  function automatic int rc_delta_width(input int n_ren, input int n_iss);
    int n_max;
    n_max = (n_ren > n_iss) ? n_ren : n_iss;
    return $clog2(n_max + 2);
  endfunction

endpackage

// File: rtl/rc_match_count.sv
`timescale 1ns/1ps
// Counts how many valid tags select register IDX, plus one optional extra hit.
module rc_match_count #(
  parameter int N     = 2,
  parameter int TAG_W = 6,
  parameter int OUT_W = 2,
  parameter int IDX   = 0
) (
  input  logic [N-1:0]       vld,
  input  logic [N*TAG_W-1:0] tags,
  input  logic               extra,
  output logic [OUT_W-1:0]   hits
);

  always_comb begin
    hits = OUT_W'(extra);
    for (int k = 0; k < N; k++) begin
      if (vld[k] && (tags[k*TAG_W +: TAG_W] == TAG_W'(IDX))) begin
        hits = hits + OUT_W'(1);
      end
    end
  end

endmodule

// File: rtl/rc_slot.sv
`timescale 1ns/1ps
// State of one physical register: use counter, replaced flag, free bit.
module rc_slot
  import rc_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int DELTA_W    = 2,
  parameter bit RESET_FREE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DELTA_W-1:0] inc,     // offered increments this cycle
  input  logic [DELTA_W-1:0] dec,     // decrements this cycle (always applied)
  input  logic               accept,  // increment side accepted
  input  logic               alloc,   // this register is the new destination
  input  logic               retire,  // this register is being replaced
  output logic               free_o,
  output logic               freed_o,
  output logic               ovf_o
);

  localparam int SUM_W = CNT_W + 2;
  localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'((1 << CNT_W) - 1);

  logic [CNT_W-1:0] cnt_q;
  rc_flags_t        flg_q;
  logic             freed_q;

  logic [SUM_W-1:0] inc_x, dec_x, peak, nxt_sum;
  logic [CNT_W-1:0] nxt_cnt;
  logic             nxt_ren, take, release_now;

  assign inc_x = SUM_W'(inc);
  assign dec_x = SUM_W'(dec);
  assign peak  = SUM_W'(cnt_q) + inc_x;
  assign ovf_o = (inc != '0) && (peak > CNT_MAX);

  always_comb begin
    nxt_sum     = SUM_W'(cnt_q) + (accept ? inc_x : '0) - dec_x;
    nxt_cnt     = nxt_sum[CNT_W-1:0];
    nxt_ren     = flg_q.renamed | (accept & retire);
    take        = accept & alloc;
    release_now = !flg_q.free && !take && nxt_ren && (nxt_cnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      flg_q   <= '{free: RESET_FREE, renamed: 1'b0};
      freed_q <= 1'b0;
    end else if (take) begin
      cnt_q   <= '0;
      flg_q   <= '{free: 1'b0, renamed: 1'b0};
      freed_q <= 1'b0;
    end else if (flg_q.free) begin
      freed_q <= 1'b0;
    end else if (release_now) begin
      cnt_q   <= '0;
      flg_q   <= '{free: 1'b1, renamed: 1'b0};
      freed_q <= 1'b1;
    end else begin
      cnt_q         <= nxt_cnt;
      flg_q.renamed <= nxt_ren;
      freed_q       <= 1'b0;
    end
  end

  assign free_o  = flg_q.free;
  assign freed_o = freed_q;

endmodule

// File: rtl/rc_preg_reclaim.sv
`timescale 1ns/1ps
module rc_preg_reclaim
  import rc_pkg::*;
#(
  parameter int NUM_PREGS = 64,
  parameter int NUM_LOG   = 16,
  parameter int CNT_W     = 4,
  parameter int REN_SRCS  = 2,
  parameter int ISS_SRCS  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ren_valid,
  output logic                          ren_ready,
  input  logic [REN_SRCS-1:0]           ren_src_vld,
  input  logic [REN_SRCS*$clog2(NUM_PREGS)-1:0] ren_src_tag,
  input  logic                          ren_dst_vld,
  input  logic [$clog2(NUM_PREGS)-1:0]  ren_old_tag,
  input  logic [$clog2(NUM_PREGS)-1:0]  ren_new_tag,
  input  logic [ISS_SRCS-1:0]           iss_src_vld,
  input  logic [ISS_SRCS*$clog2(NUM_PREGS)-1:0] iss_src_tag,
  input  logic                          ckpt_take,
  input  logic [NUM_PREGS-1:0]          ckpt_take_mask,
  input  logic                          ckpt_drop,
  input  logic [NUM_PREGS-1:0]          ckpt_drop_mask,
  output logic [NUM_PREGS-1:0]          free_vec,
  output logic [NUM_PREGS-1:0]          freed_mask
);

  localparam int TAG_W   = $clog2(NUM_PREGS);
  localparam int DELTA_W = rc_delta_width(REN_SRCS, ISS_SRCS);

  logic [REN_SRCS-1:0]  ren_hit_vld;
  logic [NUM_PREGS-1:0] ovf_vec;
  logic                 accept;
  logic                 dst_event;

  assign ren_hit_vld = ren_src_vld & {REN_SRCS{ren_valid}};
  assign dst_event   = ren_valid & ren_dst_vld;
  assign ren_ready   = ~|ovf_vec;   // R3: stall on any would-be overflow
  assign accept      = ren_ready;

  for (genvar g = 0; g < NUM_PREGS; g++) begin : g_reg
    logic [DELTA_W-1:0] inc_g, dec_g;
    logic               alloc_g, retire_g;

    rc_match_count #(
      .N(REN_SRCS), .TAG_W(TAG_W), .OUT_W(DELTA_W), .IDX(g)
    ) u_inc (
      .vld  (ren_hit_vld),
      .tags (ren_src_tag),
      .extra(ckpt_take & ckpt_take_mask[g]),
      .hits (inc_g)
    );

    rc_match_count #(
      .N(ISS_SRCS), .TAG_W(TAG_W), .OUT_W(DELTA_W), .IDX(g)
    ) u_dec (
      .vld  (iss_src_vld),
      .tags (iss_src_tag),
      .extra(ckpt_drop & ckpt_drop_mask[g]),
      .hits (dec_g)
    );

    assign alloc_g  = dst_event && (ren_new_tag == TAG_W'(g));
    assign retire_g = dst_event && (ren_old_tag == TAG_W'(g));

    rc_slot #(
      .CNT_W(CNT_W), .DELTA_W(DELTA_W), .RESET_FREE(g >= NUM_LOG)
    ) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (inc_g),
      .dec    (dec_g),
      .accept (accept),
      .alloc  (alloc_g),
      .retire (retire_g),
      .free_o (free_vec[g]),
      .freed_o(freed_mask[g]),
      .ovf_o  (ovf_vec[g])
    );
  end

endmodule

// File: rtl/rc_preg_reclaim_chk.sv
`timescale 1ns/1ps
module rc_preg_reclaim_chk #(
  parameter int NUM_PREGS = 64,
  parameter int TAG_W     = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ren_valid,
  input logic                 ren_ready,
  input logic                 ren_dst_vld,
  input logic [TAG_W-1:0]     ren_new_tag,
  input logic                 ckpt_take,
  input logic [NUM_PREGS-1:0] free_vec,
  input logic [NUM_PREGS-1:0] freed_mask
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R7: the freed pulse marks exactly the free bits that rose at this edge
  assert_freed_matches_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (freed_mask == (free_vec & ~$past(free_vec))));

  // R8: an accepted allocation leaves the new register out of the pool
  assert_alloc_clears_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(ren_valid && ren_ready && ren_dst_vld)) |-> !free_vec[$past(ren_new_tag)]);

  // R3: a stalled cycle allocates nothing
  assert_stall_blocks_alloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(!ren_ready)) |-> ((~free_vec & $past(free_vec)) == '0));

  // R3: without offered increments the block never stalls
  assert_ready_without_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ren_valid && !ckpt_take) |-> ren_ready);

endmodule

bind rc_preg_reclaim rc_preg_reclaim_chk #(.NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/rc_preg_reclaim_tb.sv
`timescale 1ns/1ps
module rc_preg_reclaim_tb;
  localparam int NP = 64, NL = 16, TW = 6, MAXC = 15, CQ = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ren_valid, ren_ready, ren_dst_vld, ckpt_take, ckpt_drop;
  logic [1:0] ren_src_vld, iss_src_vld;
  logic [2*TW-1:0] ren_src_tag, iss_src_tag;
  logic [TW-1:0] ren_old_tag, ren_new_tag;
  logic [NP-1:0] ckpt_take_mask, ckpt_drop_mask, free_vec, freed_mask;

  rc_preg_reclaim u_dut (.*);

  int mcnt[NP]; bit mren[NP]; bit mfree[NP]; int pend[NP]; int lmap[NL];
  logic [NP-1:0] cq[CQ]; int cq_n, cq_head;
  int ren_lr, checks, fails; bit done;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    ren_valid = 0; ren_dst_vld = 0; ren_src_vld = 0; ren_src_tag = 0;
    ren_old_tag = 0; ren_new_tag = 0; iss_src_vld = 0; iss_src_tag = 0;
    ckpt_take = 0; ckpt_take_mask = 0; ckpt_drop = 0; ckpt_drop_mask = 0;
  endtask

  function automatic logic [NP-1:0] model_free();
    logic [NP-1:0] v;
    for (int r = 0; r < NP; r++) v[r] = mfree[r];
    return v;
  endfunction

  function automatic logic [NP-1:0] map_mask();
    logic [NP-1:0] m = '0;
    for (int l = 0; l < NL; l++) m[lmap[l]] = 1'b1;
    return m;
  endfunction

  function automatic int ren_hits(input int r);
    int n = 0;
    for (int k = 0; k < 2; k++)
      if (ren_valid && ren_src_vld[k] && ren_src_tag[k*TW +: TW] == TW'(r)) n++;
    if (ckpt_take && ckpt_take_mask[r]) n++;
    return n;
  endfunction

  function automatic int iss_hits(input int r);
    int n = 0;
    for (int k = 0; k < 2; k++)
      if (iss_src_vld[k] && iss_src_tag[k*TW +: TW] == TW'(r)) n++;
    if (ckpt_drop && ckpt_drop_mask[r]) n++;
    return n;
  endfunction

  function automatic bit exp_ready();
    for (int r = 0; r < NP; r++) begin
      int h = ren_hits(r);
      if (h > 0 && mcnt[r] + h > MAXC) return 1'b0;
    end
    return 1'b1;
  endfunction

  // One cycle: inputs are already set just after a falling edge.
  task automatic step(input string tag, output bit acc);
    logic [NP-1:0] efreed = '0;
    #1;
    acc = exp_ready();
    check(ren_ready === acc, tag, "ren_ready (R3)", 64'(ren_ready), 64'(acc));
    for (int r = 0; r < NP; r++) begin
      int inc = acc ? ren_hits(r) : 0;
      int dec = iss_hits(r);
      bit dst = acc && ren_valid && ren_dst_vld;
      if (dst && ren_new_tag == TW'(r)) begin
        mcnt[r] = 0; mren[r] = 0; mfree[r] = 0;
      end else if (!mfree[r]) begin
        int nc = mcnt[r] + inc - dec;
        bit nr = mren[r] | (dst && ren_old_tag == TW'(r));
        if (nr && nc == 0) begin
          mfree[r] = 1; mren[r] = 0; mcnt[r] = 0; efreed[r] = 1'b1;
        end else begin
          mcnt[r] = nc; mren[r] = nr;
        end
      end
    end
    if (acc && ren_valid) begin
      for (int k = 0; k < 2; k++) if (ren_src_vld[k]) pend[ren_src_tag[k*TW +: TW]]++;
      if (ren_dst_vld) lmap[ren_lr] = int'(ren_new_tag);
    end
    for (int k = 0; k < 2; k++) if (iss_src_vld[k]) pend[iss_src_tag[k*TW +: TW]]--;
    if (ckpt_drop) begin cq_head = (cq_head + 1) % CQ; cq_n--; end
    if (acc && ckpt_take) begin cq[(cq_head + cq_n) % CQ] = ckpt_take_mask; cq_n++; end
    @(posedge clk); @(negedge clk);
    check(free_vec === model_free(), tag, "free_vec (R7/R8)", free_vec, model_free());
    check(freed_mask === efreed, tag, "freed_mask (R7)", freed_mask, efreed);
    idle();
  endtask

  task automatic first_free(output int r, output bit ok);
    int s = $urandom % NP;
    ok = 0; r = 0;
    for (int i = 0; i < NP; i++) if (!ok && mfree[(s + i) % NP]) begin r = (s + i) % NP; ok = 1; end
  endtask

  task automatic rand_cycle();
    bit acc, ok; int nr, s;
    ren_valid = ($urandom % 10) < 7;
    ren_lr = $urandom % NL;
    ren_old_tag = TW'(lmap[ren_lr]);
    first_free(nr, ok);
    ren_dst_vld = ok && ($urandom % 4 != 0);
    ren_new_tag = TW'(nr);
    for (int k = 0; k < 2; k++) begin
      ren_src_vld[k] = $urandom % 2;
      ren_src_tag[k*TW +: TW] = TW'(lmap[$urandom % NL]);
    end
    for (int k = 0; k < 2; k++) begin
      s = $urandom % NP;
      for (int i = 0; i < NP; i++) begin
        int r = (s + i) % NP;
        int avail = pend[r] - ((k == 1 && iss_src_vld[0] && iss_src_tag[TW-1:0] == TW'(r)) ? 1 : 0);
        if (!iss_src_vld[k] && avail > 0 && ($urandom % 2 == 0)) begin
          iss_src_vld[k] = 1; iss_src_tag[k*TW +: TW] = TW'(r);
        end
      end
    end
    if (cq_n < 8 && $urandom % 16 == 0) begin ckpt_take = 1; ckpt_take_mask = map_mask(); end
    if (cq_n > 0 && $urandom % 16 == 0) begin ckpt_drop = 1; ckpt_drop_mask = cq[cq_head]; end
    step("random", acc);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog R1 act=%h exp=%h", 64'(0), 64'(1));
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit acc; int nf; bit ok; logic [NP-1:0] fv;
    void'($urandom(32'h5eed_0c41));
    idle(); rst_n = 0;
    for (int r = 0; r < NP; r++) begin mcnt[r] = 0; mren[r] = 0; mfree[r] = (r >= NL); pend[r] = 0; end
    for (int l = 0; l < NL; l++) lmap[l] = l;
    cq_n = 0; cq_head = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    // R1: reset state
    check(free_vec === 64'hFFFF_FFFF_FFFF_0000, "R1", "free_vec", free_vec, 64'hFFFF_FFFF_FFFF_0000);
    check(freed_mask === '0, "R1", "freed_mask", freed_mask, 64'h0);
    check(ren_ready === 1'b1, "R1", "ren_ready", 64'(ren_ready), 64'h1);

    // R2 / R8: replace p0 while the same event reads it
    ren_valid = 1; ren_lr = 0; ren_old_tag = 0; ren_dst_vld = 1; ren_new_tag = 16;
    ren_src_vld = 2'b01; ren_src_tag = {6'd0, 6'd0};
    step("R2", acc);
    check(free_vec[0] === 1'b0, "R2", "replaced but read p0 held", 64'(free_vec[0]), 64'h0);
    check(free_vec[16] === 1'b0, "R8", "allocated p16 leaves pool", 64'(free_vec[16]), 64'h0);
    // R4 / R7: the issue read releases p0
    iss_src_vld = 2'b01; iss_src_tag = {6'd0, 6'd0};
    step("R4", acc);
    check(freed_mask === 64'h1, "R7", "freed pulse p0", freed_mask, 64'h1);
    step("R7", acc);
    check(freed_mask === '0, "R7", "freed pulse one cycle", freed_mask, 64'h0);

    // R5: a checkpoint holds a replaced register until it is dropped
    ckpt_take = 1; ckpt_take_mask = map_mask();
    step("R5", acc);
    first_free(nf, ok);
    ren_valid = 1; ren_lr = 1; ren_old_tag = TW'(lmap[1]); ren_dst_vld = 1; ren_new_tag = TW'(nf);
    step("R5", acc);
    check(free_vec[1] === 1'b0, "R5", "checkpoint holds p1", 64'(free_vec[1]), 64'h0);
    ckpt_drop = 1; ckpt_drop_mask = cq[cq_head];
    step("R5", acc);
    check(freed_mask[1] === 1'b1, "R5", "drop frees p1", 64'(freed_mask[1]), 64'h1);

    // R3: saturate p2 through checkpoint captures
    for (int i = 0; i < MAXC; i++) begin
      ckpt_take = 1; ckpt_take_mask = 64'h4; step("R3", acc);
    end
    ckpt_take = 1; ckpt_take_mask = 64'h4; #1;
    check(ren_ready === 1'b0, "R3", "stall on 16th capture", 64'(ren_ready), 64'h0);
    step("R3", acc);
    first_free(nf, ok);
    ren_valid = 1; ren_lr = 2; ren_old_tag = 2; ren_dst_vld = 1; ren_new_tag = TW'(nf);
    ren_src_vld = 2'b01; ren_src_tag = {6'd0, 6'd2}; #1;
    check(ren_ready === 1'b0, "R3", "stall on rename read", 64'(ren_ready), 64'h0);
    fv = free_vec;
    step("R3", acc);
    check(free_vec === fv, "R3", "rejected event no effect", free_vec, fv);
    while (cq_n > 0) begin
      ckpt_drop = 1; ckpt_drop_mask = cq[cq_head]; step("R5", acc);
    end

    // R6: add and subtract on p3 in one cycle
    ren_valid = 1; ren_src_vld = 2'b01; ren_src_tag = {6'd0, 6'd3};
    step("R6", acc);
    first_free(nf, ok);
    ren_valid = 1; ren_lr = 3; ren_old_tag = 3; ren_dst_vld = 1; ren_new_tag = TW'(nf);
    ren_src_vld = 2'b01; ren_src_tag = {6'd0, 6'd3};
    iss_src_vld = 2'b01; iss_src_tag = {6'd0, 6'd3};
    step("R6", acc);
    check(free_vec[3] === 1'b0, "R6", "net zero keeps p3 held", 64'(free_vec[3]), 64'h0);
    iss_src_vld = 2'b01; iss_src_tag = {6'd0, 6'd3};
    step("R6", acc);
    check(freed_mask[3] === 1'b1, "R6", "last read frees p3", 64'(freed_mask[3]), 64'h1);

    // Mixed random traffic (R2 R4 R5 R7 R8)
    for (int i = 0; i < 4000; i++) rand_cycle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule